// File: doc/BRIEF.md
# Split-Tagged Dual-Half Warp Instruction Buffer

This block holds the decoded instructions of one warp ahead of issue. Its slots are split into two halves. The primary half serves the warp's main thread group through an issue pointer. The secondary half holds instructions of a second, divergent thread group that a scheduler may pair with the primary one. Each slot records four things when it is written: the instruction word, a valid bit, the identifier of the divergence split it belongs to and that split's thread mask. The scheduler can then tell which threads an entry belongs to.

Each half can also be bound to a split. The binding is an identifier, a mask and a flag, and it stays readable until that half is flushed. A saturating in-flight counter follows how many instructions have entered the buffer and not yet been discarded by a flush.

Top module: `split_ibuf`

## Requirements
- R1: There are 4 slots. Slots 0 and 1 are the primary half (half 0) and slots 2 and 3 are the secondary half (half 1). A fill writes the instruction, the split id and the mask into `fill_slot` and sets that slot valid. The new contents are visible on the read ports in the next cycle.
- R2: A fill with `fill_has_split` low stores split id 15, which means "none" (all ones in 4 bits), and a zero mask. The id and mask inputs are ignored.
- R3: A fill into the primary half sets the issue pointer to 0. A fill into the secondary half leaves the issue pointer unchanged.
- R4: `iss_step` advances the issue pointer modulo 2, so it only ever addresses slot 0 or slot 1.
- R5: `half_empty[h]` is high exactly when no slot of half h is valid. `any_half_empty` is high when either half is empty.
- R6: Flushing one half does four things. It invalidates that half's slots, sets their split ids to 15, clears the half's assigned flag and lowers the in-flight count by the number of its slots that were valid.
- R7: A full flush applies R6 to both halves in one cycle.
- R8: Assigning a half sets its assigned flag and stores an id and a mask. They stay unchanged, including across a flush of the other half, until that half itself is flushed.
- R9: A direct free clears only the valid bit. `iss_free` frees the slot at the issue pointer and `sec_free_en` frees a secondary slot. The issue pointer and the in-flight count do not change.
- R10: In one cycle, a fill wins over a free or a flush of the same slot. A primary fill also wins over `iss_step`.
- R11: The 6-bit in-flight count rises by 1 per fill, stays at 63 once there, and never goes below 0.
- R12: After reset every slot is invalid, the issue pointer is 0, the count is 0 and neither half is assigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Write one slot |
| fill_slot | input | 2 | Slot to write |
| fill_insn | input | 32 | Instruction word |
| fill_has_split | input | 1 | Split id and mask inputs are meaningful |
| fill_split_id | input | 4 | Split identifier |
| fill_mask | input | 32 | Split thread mask |
| iss_step | input | 1 | Advance the primary issue pointer |
| iss_free | input | 1 | Invalidate the slot under the issue pointer |
| iss_ptr | output | 1 | Issue pointer within the primary half |
| iss_valid | output | 1 | Slot under the pointer is valid |
| iss_insn | output | 32 | Instruction under the pointer |
| iss_split_id | output | 4 | Split id under the pointer |
| iss_mask | output | 32 | Mask under the pointer |
| sec_rd_slot | input | 1 | Secondary slot to read (0 = slot 2, 1 = slot 3) |
| sec_valid | output | 1 | Read secondary slot is valid |
| sec_insn | output | 32 | Read secondary instruction |
| sec_split_id | output | 4 | Read secondary split id |
| sec_mask | output | 32 | Read secondary mask |
| sec_free_en | input | 1 | Invalidate one secondary slot |
| sec_free_slot | input | 1 | Secondary slot to free |
| flush_half_en | input | 1 | Flush one half |
| flush_half_sel | input | 1 | Half to flush |
| flush_all | input | 1 | Flush both halves |
| assign_en | input | 1 | Bind a half to a split |
| assign_half | input | 1 | Half to bind |
| assign_split_id | input | 4 | Bound split id |
| assign_mask | input | 32 | Bound split mask |
| half_empty | output | 2 | Per-half empty flags |
| any_half_empty | output | 1 | At least one half empty |
| half_assigned | output | 2 | Per-half assigned flags |
| half_split_id | output | 8 | Bound ids, half h in bits [4h+3:4h] |
| half_mask | output | 64 | Bound masks, half h in bits [32h+31:32h] |
| inflight | output | 6 | Saturating in-flight count |

## Verification
The hardest situations to reach are same-cycle collisions. Examples are a fill arriving while its own half is flushed or its own slot is freed, and a primary fill arriving while the pointer steps. The stimulus sets up known slot contents first and then raises the colliding controls together in a single cycle. Reaching the 63 ceiling of the in-flight count needs dozens of refills of one slot with no flush in between. The bench issues exactly that run and then a single flush to show the count leaves the ceiling by the valid-slot count.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

  // Next issue position inside one half.
  function automatic int unsigned ptr_advance(input int unsigned p,
                                              input int unsigned half_sz);
    return (p + 1) % half_sz;
  endfunction

  // Counter update clamped to [0, maxv].
  function automatic int unsigned sat_step(input int unsigned cur,
                                           input int unsigned inc,
                                           input int unsigned dec,
                                           input int unsigned maxv);
    int unsigned up;
    up = cur + inc;
    if (up < dec) return 0;
    if (up - dec > maxv) return maxv;
    return up - dec;
  endfunction

endpackage

// File: rtl/ibuf_slot.sv
module ibuf_slot #(
  parameter int INSN_W = 32,
  parameter int SID_W  = 4,
  parameter int MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [INSN_W-1:0] wr_insn,
  input  logic [SID_W-1:0]  wr_sid,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic              drop,
  input  logic              scrub,
  output logic              vld,
  output logic [INSN_W-1:0] insn,
  output logic [SID_W-1:0]  sid,
  output logic [MASK_W-1:0] mask
);
  localparam logic [SID_W-1:0] SID_NONE = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      insn <= '0;
      sid  <= SID_NONE;
      mask <= '0;
    end else if (wr_en) begin
      vld  <= 1'b1;
      insn <= wr_insn;
      sid  <= wr_sid;
      mask <= wr_mask;
    end else if (scrub) begin
      vld <= 1'b0;
      sid <= SID_NONE;
    end else if (drop) begin
      vld <= 1'b0;
    end
  end

  AST_FILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld && insn == $past(wr_insn) && sid == $past(wr_sid)); // R10
  AST_SCRUB_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (scrub && !wr_en) |=> !vld && sid == SID_NONE); // R6
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !scrub && !wr_en) |=> !vld && $stable(insn) && $stable(sid)); // R9
endmodule

// File: rtl/ibuf_half_tag.sv
module ibuf_half_tag #(
  parameter int SID_W  = 4,
  parameter int MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bind_en,
  input  logic [SID_W-1:0]  bind_sid,
  input  logic [MASK_W-1:0] bind_mask,
  input  logic              unbind,
  output logic              bound,
  output logic [SID_W-1:0]  sid,
  output logic [MASK_W-1:0] mask
);
  localparam logic [SID_W-1:0] SID_NONE = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound <= 1'b0;
      sid   <= SID_NONE;
      mask  <= '0;
    end else if (bind_en) begin
      bound <= 1'b1;
      sid   <= bind_sid;
      mask  <= bind_mask;
    end else if (unbind) begin
      bound <= 1'b0;
      sid   <= SID_NONE;
      mask  <= '0;
    end
  end

  AST_BIND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bound && !bind_en && !unbind) |=> bound && $stable(sid) && $stable(mask)); // R8
  AST_UNBIND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (unbind && !bind_en) |=> !bound); // R6
endmodule

// File: rtl/ibuf_inflight.sv
module ibuf_inflight #(
  parameter int CNT_W = 6,
  parameter int DEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [DEC_W-1:0] dec,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else cnt <= CNT_W'(ibuf_pkg::sat_step(32'(cnt), 32'(inc), 32'(dec),
                                          32'(CNT_MAX)));
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && inc && dec == '0) |=> cnt == CNT_MAX); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !inc) |=> cnt == '0); // R11
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != CNT_MAX && inc && dec == '0) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R11
endmodule

// File: rtl/split_ibuf.sv
module split_ibuf #(
  parameter int INSN_W     = 32,
  parameter int SID_W      = 4,
  parameter int MASK_W     = 32,
  parameter int HALF_SLOTS = 2,
  parameter int HALVES     = 2,
  parameter int CNT_W      = 6,
  localparam int SLOTS  = HALF_SLOTS * HALVES,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PTR_W  = (HALF_SLOTS > 1) ? $clog2(HALF_SLOTS) : 1,
  localparam int HSEL_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fill_en,
  input  logic [SLOT_W-1:0]        fill_slot,
  input  logic [INSN_W-1:0]        fill_insn,
  input  logic                     fill_has_split,
  input  logic [SID_W-1:0]         fill_split_id,
  input  logic [MASK_W-1:0]        fill_mask,
  input  logic                     iss_step,
  input  logic                     iss_free,
  output logic [PTR_W-1:0]         iss_ptr,
  output logic                     iss_valid,
  output logic [INSN_W-1:0]        iss_insn,
  output logic [SID_W-1:0]         iss_split_id,
  output logic [MASK_W-1:0]        iss_mask,
  input  logic [PTR_W-1:0]         sec_rd_slot,
  output logic                     sec_valid,
  output logic [INSN_W-1:0]        sec_insn,
  output logic [SID_W-1:0]         sec_split_id,
  output logic [MASK_W-1:0]        sec_mask,
  input  logic                     sec_free_en,
  input  logic [PTR_W-1:0]         sec_free_slot,
  input  logic                     flush_half_en,
  input  logic [HSEL_W-1:0]        flush_half_sel,
  input  logic                     flush_all,
  input  logic                     assign_en,
  input  logic [HSEL_W-1:0]        assign_half,
  input  logic [SID_W-1:0]         assign_split_id,
  input  logic [MASK_W-1:0]        assign_mask,
  output logic [HALVES-1:0]        half_empty,
  output logic                     any_half_empty,
  output logic [HALVES-1:0]        half_assigned,
  output logic [HALVES*SID_W-1:0]  half_split_id,
  output logic [HALVES*MASK_W-1:0] half_mask,
  output logic [CNT_W-1:0]         inflight
);
  localparam int DEC_W = $clog2(SLOTS + 1);
  localparam logic [SID_W-1:0] SID_NONE = '1;

  // Named internal events
  logic [SLOTS-1:0]  slot_vld;
  logic [INSN_W-1:0] slot_insn [SLOTS];
  logic [SID_W-1:0]  slot_sid  [SLOTS];
  logic [MASK_W-1:0] slot_mask [SLOTS];
  logic [SLOTS-1:0]  flush_vec;
  logic [DEC_W-1:0]  flush_drop_cnt;
  logic [SID_W-1:0]  fill_sid_eff;
  logic [MASK_W-1:0] fill_mask_eff;
  logic              fill_primary;
  logic [HSEL_W-1:0] fill_half;
  logic [PTR_W-1:0]  ptr_q;

  assign fill_sid_eff  = fill_has_split ? fill_split_id : SID_NONE;
  assign fill_mask_eff = fill_has_split ? fill_mask : '0;
  assign fill_primary  = fill_en && (fill_slot < SLOT_W'(HALF_SLOTS));
  assign fill_half     = HSEL_W'(fill_slot >> PTR_W);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int H = s / HALF_SLOTS;
    logic wr_hit, drop_hit;
    assign wr_hit = fill_en && fill_slot == SLOT_W'(s);
    assign flush_vec[s] = flush_all || (flush_half_en && flush_half_sel == HSEL_W'(H));
    if (H == 0) begin : g_pri
      assign drop_hit = iss_free && ptr_q == PTR_W'(s);
    end else if (H == 1) begin : g_sec
      assign drop_hit = sec_free_en && sec_free_slot == PTR_W'(s - HALF_SLOTS);
    end else begin : g_other
      assign drop_hit = 1'b0;
    end
    ibuf_slot #(.INSN_W(INSN_W), .SID_W(SID_W), .MASK_W(MASK_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_hit), .wr_insn(fill_insn), .wr_sid(fill_sid_eff),
      .wr_mask(fill_mask_eff), .drop(drop_hit), .scrub(flush_vec[s]),
      .vld(slot_vld[s]), .insn(slot_insn[s]), .sid(slot_sid[s]),
      .mask(slot_mask[s])
    );
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half_empty[h] = ~|slot_vld[h*HALF_SLOTS +: HALF_SLOTS];
    ibuf_half_tag #(.SID_W(SID_W), .MASK_W(MASK_W)) u_tag (
      .clk(clk), .rst_n(rst_n),
      .bind_en(assign_en && assign_half == HSEL_W'(h)),
      .bind_sid(assign_split_id), .bind_mask(assign_mask),
      .unbind(flush_all || (flush_half_en && flush_half_sel == HSEL_W'(h))),
      .bound(half_assigned[h]),
      .sid(half_split_id[h*SID_W +: SID_W]),
      .mask(half_mask[h*MASK_W +: MASK_W])
    );
  end
  assign any_half_empty = |half_empty;

  always_comb begin
    flush_drop_cnt = '0;
    for (int i = 0; i < SLOTS; i++)
      flush_drop_cnt += DEC_W'(slot_vld[i] & flush_vec[i]);
  end

  ibuf_inflight #(.CNT_W(CNT_W), .DEC_W(DEC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(fill_en), .dec(flush_drop_cnt),
    .cnt(inflight)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ptr_q <= '0;
    else if (fill_primary) ptr_q <= '0;
    else if (iss_step)     ptr_q <= PTR_W'(ibuf_pkg::ptr_advance(32'(ptr_q), HALF_SLOTS));
  end
  assign iss_ptr = ptr_q;

  logic [SLOT_W-1:0] iss_idx, sec_idx;
  assign iss_idx = SLOT_W'(ptr_q);
  assign sec_idx = SLOT_W'(HALF_SLOTS) + SLOT_W'(sec_rd_slot);

  assign iss_valid    = slot_vld[iss_idx];
  assign iss_insn     = slot_insn[iss_idx];
  assign iss_split_id = slot_sid[iss_idx];
  assign iss_mask     = slot_mask[iss_idx];
  assign sec_valid    = slot_vld[sec_idx];
  assign sec_insn     = slot_insn[sec_idx];
  assign sec_split_id = slot_sid[sec_idx];
  assign sec_mask     = slot_mask[sec_idx];

  AST_PRI_FILL_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    fill_primary |=> iss_ptr == '0); // R3
  AST_SEC_FILL_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_primary && !iss_step) |=> $stable(iss_ptr)); // R3
  AST_FILL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> !half_empty[$past(fill_half)]); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_half_en && !(fill_en && fill_half == flush_half_sel))
      |=> half_empty[$past(flush_half_sel)]); // R6
  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_en) |=> &half_empty); // R7
endmodule

// File: tb/split_ibuf_bench.sv
`timescale 1ns/1ps
module split_ibuf_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        fill_en, fill_has_split, iss_step, iss_free;
  logic [1:0]  fill_slot;
  logic [31:0] fill_insn, fill_mask, assign_mask;
  logic [3:0]  fill_split_id, assign_split_id;
  logic        sec_rd_slot, sec_free_en, sec_free_slot;
  logic        flush_half_en, flush_half_sel, flush_all, assign_en, assign_half;
  logic        iss_ptr, iss_valid, sec_valid, any_half_empty;
  logic [31:0] iss_insn, iss_mask, sec_insn, sec_mask;
  logic [3:0]  iss_split_id, sec_split_id;
  logic [1:0]  half_empty, half_assigned;
  logic [7:0]  half_split_id;
  logic [63:0] half_mask;
  logic [5:0]  inflight;

  split_ibuf u_split_ibuf (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_slot(fill_slot), .fill_insn(fill_insn),
    .fill_has_split(fill_has_split), .fill_split_id(fill_split_id),
    .fill_mask(fill_mask), .iss_step(iss_step), .iss_free(iss_free),
    .iss_ptr(iss_ptr), .iss_valid(iss_valid), .iss_insn(iss_insn),
    .iss_split_id(iss_split_id), .iss_mask(iss_mask),
    .sec_rd_slot(sec_rd_slot), .sec_valid(sec_valid), .sec_insn(sec_insn),
    .sec_split_id(sec_split_id), .sec_mask(sec_mask),
    .sec_free_en(sec_free_en), .sec_free_slot(sec_free_slot),
    .flush_half_en(flush_half_en), .flush_half_sel(flush_half_sel),
    .flush_all(flush_all), .assign_en(assign_en), .assign_half(assign_half),
    .assign_split_id(assign_split_id), .assign_mask(assign_mask),
    .half_empty(half_empty), .any_half_empty(any_half_empty),
    .half_assigned(half_assigned), .half_split_id(half_split_id),
    .half_mask(half_mask), .inflight(inflight)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    fill_en = 0; fill_has_split = 0; iss_step = 0; iss_free = 0;
    sec_free_en = 0; flush_half_en = 0; flush_all = 0; assign_en = 0;
  endtask

  // Apply the controls set since the last negedge for one clock.
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic put(input int slot, input logic [31:0] insn,
                     input logic [3:0] sid, input logic [31:0] msk);
    fill_en = 1; fill_slot = 2'(slot); fill_insn = insn;
    fill_has_split = 1; fill_split_id = sid; fill_mask = msk;
  endtask

  // Ops: 0 fill, 1 fill without split, 2 step, 3 flush half (slot[1]),
  // 4 flush all, 5 free at pointer, 6 free secondary (slot[0])
  // Vector: {op[2:0], slot[1:0], cnt[5:0], empty[1:0], ptr}
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {3'd0, 2'd2, 6'd1, 2'b01, 1'b0},
    {3'd0, 2'd1, 6'd2, 2'b00, 1'b0},
    {3'd2, 2'd0, 6'd2, 2'b00, 1'b1},
    {3'd0, 2'd3, 6'd3, 2'b00, 1'b1},
    {3'd2, 2'd0, 6'd3, 2'b00, 1'b0},
    {3'd2, 2'd0, 6'd3, 2'b00, 1'b1},
    {3'd5, 2'd0, 6'd3, 2'b01, 1'b1},
    {3'd0, 2'd0, 6'd4, 2'b00, 1'b0},
    {3'd6, 2'd2, 6'd4, 2'b00, 1'b0},
    {3'd3, 2'd2, 6'd3, 2'b10, 1'b0},
    {3'd1, 2'd1, 6'd4, 2'b10, 1'b0},
    {3'd4, 2'd0, 6'd2, 2'b11, 1'b0},
    {3'd4, 2'd0, 6'd2, 2'b11, 1'b0}
  };

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    fill_slot = 0; fill_insn = 0; fill_split_id = 0; fill_mask = 0;
    sec_rd_slot = 0; sec_free_slot = 0; flush_half_sel = 0;
    assign_half = 0; assign_split_id = 0; assign_mask = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12 reset state
    chk("R12", "inflight", 64'(inflight), 64'd0);
    chk("R12", "half_empty", 64'(half_empty), 64'b11);
    chk("R12", "iss_ptr", 64'(iss_ptr), 64'd0);
    chk("R12", "half_assigned", 64'(half_assigned), 64'd0);
    chk("R12", "iss_valid", 64'(iss_valid), 64'd0);

    // Table walk: R3 R4 R5 R6 R7 R9 R11
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op; logic [1:0] sl;
      op = VEC[i][13:11]; sl = VEC[i][10:9];
      case (op)
        3'd0: put(int'(sl), 32'h100 + 32'(i), 4'(i), 32'h1 << i);
        3'd1: begin put(int'(sl), 32'h200 + 32'(i), 4'd3, 32'hFF); fill_has_split = 0; end
        3'd2: iss_step = 1;
        3'd3: begin flush_half_en = 1; flush_half_sel = sl[1]; end
        3'd4: flush_all = 1;
        3'd5: iss_free = 1;
        default: begin sec_free_en = 1; sec_free_slot = sl[0]; end
      endcase
      tick();
      chk("R11", $sformatf("vec%0d inflight", i), 64'(inflight), 64'(VEC[i][8:3]));
      chk("R5", $sformatf("vec%0d half_empty", i), 64'(half_empty), 64'(VEC[i][2:1]));
      chk("R5", $sformatf("vec%0d any_half_empty", i), 64'(any_half_empty), 64'(|VEC[i][2:1]));
      chk("R4", $sformatf("vec%0d iss_ptr", i), 64'(iss_ptr), 64'(VEC[i][0]));
    end

    // R1 contents on both read ports
    put(3, 32'hA5A5_0003, 4'd5, 32'h0000_F0F0); tick();
    sec_rd_slot = 1; #1;
    chk("R1", "sec_valid", 64'(sec_valid), 64'd1);
    chk("R1", "sec_insn", 64'(sec_insn), 64'hA5A5_0003);
    chk("R1", "sec_split_id", 64'(sec_split_id), 64'd5);
    chk("R1", "sec_mask", 64'(sec_mask), 64'h0000_F0F0);
    put(0, 32'h0000_1111, 4'd3, 32'h0000_00FF); tick();
    chk("R1", "iss_valid", 64'(iss_valid), 64'd1);
    chk("R1", "iss_insn", 64'(iss_insn), 64'h1111);
    chk("R1", "iss_split_id", 64'(iss_split_id), 64'd3);
    chk("R1", "iss_mask", 64'(iss_mask), 64'hFF);
    chk("R11", "inflight after two fills", 64'(inflight), 64'd4);

    // R2 fill without split info
    put(2, 32'h0000_2222, 4'd6, 32'hFFFF); fill_has_split = 0; tick();
    sec_rd_slot = 0; #1;
    chk("R2", "sec_split_id none", 64'(sec_split_id), 64'd15);
    chk("R2", "sec_mask cleared", 64'(sec_mask), 64'd0);
    chk("R2", "sec_insn", 64'(sec_insn), 64'h2222);

    // R8 assignment held across the other half's flush
    assign_en = 1; assign_half = 1; assign_split_id = 9; assign_mask = 32'h0F0F; tick();
    chk("R8", "half_assigned", 64'(half_assigned), 64'b10);
    chk("R8", "half_split_id", 64'(half_split_id[7:4]), 64'd9);
    chk("R8", "half_mask", 64'(half_mask[63:32]), 64'h0F0F);
    flush_half_en = 1; flush_half_sel = 0; tick();
    chk("R8", "assigned kept", 64'(half_assigned), 64'b10);
    chk("R8", "id kept", 64'(half_split_id[7:4]), 64'd9);
    chk("R6", "inflight after half0 flush", 64'(inflight), 64'd4);
    flush_half_en = 1; flush_half_sel = 1; tick();
    chk("R6", "assigned cleared", 64'(half_assigned), 64'b00);
    chk("R6", "inflight after half1 flush", 64'(inflight), 64'd2);
    sec_rd_slot = 1; #1;
    chk("R6", "flushed id none", 64'(sec_split_id), 64'd15);
    chk("R6", "flushed invalid", 64'(sec_valid), 64'd0);

    // R10 collisions
    put(2, 32'h33, 4'd1, 32'h1); sec_free_en = 1; sec_free_slot = 0; tick();
    sec_rd_slot = 0; #1;
    chk("R10", "fill beats free", 64'(sec_valid), 64'd1);
    chk("R11", "inflight", 64'(inflight), 64'd3);
    put(3, 32'h44, 4'd2, 32'h2); flush_half_en = 1; flush_half_sel = 1; tick();
    sec_rd_slot = 1; #1;
    chk("R10", "fill beats flush", 64'(sec_valid), 64'd1);
    sec_rd_slot = 0; #1;
    chk("R10", "neighbour flushed", 64'(sec_valid), 64'd0);
    chk("R10", "inflight net", 64'(inflight), 64'd3);
    iss_step = 1; tick();
    chk("R4", "step to 1", 64'(iss_ptr), 64'd1);
    put(1, 32'h55, 4'd4, 32'h4); iss_step = 1; tick();
    chk("R10", "primary fill beats step", 64'(iss_ptr), 64'd0);
    chk("R11", "inflight", 64'(inflight), 64'd4);

    // R9 free at pointer keeps pointer and count
    iss_step = 1; tick();
    chk("R9", "pointer on slot1 valid", 64'(iss_valid), 64'd1);
    iss_free = 1; tick();
    chk("R9", "freed invalid", 64'(iss_valid), 64'd0);
    chk("R9", "pointer unchanged", 64'(iss_ptr), 64'd1);
    chk("R9", "inflight unchanged", 64'(inflight), 64'd4);
    chk("R9", "freed insn kept", 64'(iss_insn), 64'h55);

    // R7 full flush, then R11 saturation
    flush_all = 1; tick();
    chk("R7", "inflight after full flush", 64'(inflight), 64'd3);
    chk("R7", "both empty", 64'(half_empty), 64'b11);
    for (int k = 0; k < 70; k++) begin
      put(0, 32'(k), 4'd0, 32'd1); tick();
    end
    chk("R11", "saturated", 64'(inflight), 64'd63);
    flush_half_en = 1; flush_half_sel = 0; tick();
    chk("R11", "leave ceiling", 64'(inflight), 64'd62);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule